// File: doc/BRIEF.md
# Power Control Command Target

This block is the receiving end of a power command channel inside one power domain. An always-on power manager sends it commands. Each command names a domain, an opcode, a scope, an element mask, a wake-up voltage mode and a transaction tag. The block keeps only commands addressed to its own domain identifier. It turns each valid command into a one-cycle action strobe for the local domain sequencer. The sequencer receives the power action, the effective element mask and the effective voltage mode.

Every command moves through four ordered phases:
- the initiator raises its request;
- the target accepts it;
- the target presents a response carrying the tag and a success flag;
- the initiator takes that response.

Responses are queued in acceptance order. This lets several tagged commands be outstanding at once, up to a parameterised limit. When the limit is reached, the block withholds request acceptance.

Top module: `pcmd_target`

## Requirements
- R1: Opcodes 0 (reset domain state), 1 (power off, no retention), 2 (power off keeping retention state) and 3 (wake to active) on `req_cmd` are dispatched. `act_valid` is high for exactly the one cycle that follows the accepting clock edge. `act_op` carries the same code and `act_tid` carries the command's tag.
- R2: A command whose `req_dom` differs from parameter `MY_DOM` is still accepted. It produces no dispatch and no response.
- R3: When `req_kind` is 0 (whole domain), `act_mask` is all ones, whatever `req_mask` holds.
- R4: When `req_kind` is 1 (selected elements), `act_mask` equals `req_mask`.
- R5: `act_vmode` equals `req_vmode` for opcode 3 and is zero for every other opcode.
- R6: A pending response keeps `rsp_valid`, `rsp_tid` and `rsp_ok` unchanged until a cycle in which `rsp_accept` is high.
- R7: A matching command with opcode 4 to 7 is not dispatched. It is answered with `rsp_ok` = 0. Opcodes 0 to 3 are answered with `rsp_ok` = 1.
- R8: Responses appear in the order their commands were accepted, each with the command's tag. The first appears in the cycle after acceptance.
- R9: While `DEPTH` matching responses are pending, `req_accept` is low. It returns high in the cycle after one response is taken.
- R10: After reset, `req_accept` is high and `act_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Initiator request begin |
| req_cmd | input | 3 | Opcode |
| req_dom | input | DOM_W | Addressed domain identifier |
| req_kind | input | 1 | 0 whole domain, 1 selected elements |
| req_mask | input | MASK_W | Element selection mask |
| req_vmode | input | VM_W | Wake-up voltage mode |
| req_tid | input | TID_W | Transaction tag |
| req_accept | output | 1 | Request accepted |
| act_valid | output | 1 | Dispatch strobe to domain sequencer |
| act_op | output | 2 | Power action |
| act_mask | output | MASK_W | Effective element mask |
| act_vmode | output | VM_W | Effective voltage mode |
| act_tid | output | TID_W | Tag of dispatched command |
| rsp_valid | output | 1 | Response begin |
| rsp_tid | output | TID_W | Tag of the answered command |
| rsp_ok | output | 1 | 1 success, 0 failure |
| rsp_accept | input | 1 | Initiator takes the response |

## Verification
The hardest state to reach is a full response queue with a further request already waiting on the stalled accept. Holding the response side idle while the initiator issues tagged commands back to back fills the queue to `DEPTH` behind a fifth request. The bench then verifies that accept stays low and the head response holds steady. It releases exactly one response, checks that the waiting command enters, and drains the rest to confirm the tag order. A sweep over all eight opcodes, both scopes and matching and foreign domains covers the decode.

// File: rtl/pcmd_pkg.sv
package pcmd_pkg;

   typedef enum logic [1:0] {
      ACT_RESET  = 2'd0,
      ACT_OFF    = 2'd1,
      ACT_RETAIN = 2'd2,
      ACT_WAKE   = 2'd3
   } pwr_act_e;

   localparam logic SCOPE_WHOLE = 1'b0;
   localparam logic SCOPE_SUBSET = 1'b1;

endpackage

// File: rtl/pcmd_decode.sv
module pcmd_decode
   import pcmd_pkg::*;
#(
   parameter int DOM_W = 7,
   parameter int MASK_W = 32,
   parameter int VM_W = 3,
   parameter logic [DOM_W-1:0] MY_DOM = '0
) (
   input  logic [2:0]        cmd,
   input  logic [DOM_W-1:0]  dom,
   input  logic              kind,
   input  logic [MASK_W-1:0] mask,
   input  logic [VM_W-1:0]   vmode,
   output logic              hit,
   output logic              known,
   output pwr_act_e          op,
   output logic [MASK_W-1:0] eff_mask,
   output logic [VM_W-1:0]   eff_vmode
);

   always_comb begin
      hit       = (dom == MY_DOM);
      known     = ~cmd[2];
      op        = pwr_act_e'(cmd[1:0]);
      eff_mask  = (kind == SCOPE_SUBSET) ? mask : {MASK_W{1'b1}};
      eff_vmode = (known && op == ACT_WAKE) ? vmode : '0;
   end

endmodule

// File: rtl/pcmd_resp_fifo.sv
module pcmd_resp_fifo #(
   parameter int DEPTH = 4,
   parameter int TID_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [TID_W-1:0] push_tid,
   input  logic             push_ok,
   input  logic             pop,
   output logic             full,
   output logic             empty,
   output logic [TID_W-1:0] head_tid,
   output logic             head_ok
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [TID_W-1:0] tid_q [DEPTH];
   logic             ok_q  [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    count;
   logic             do_push, do_pop;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head_tid = tid_q[rd_ptr];
   assign head_ok  = ok_q[rd_ptr];

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         tid_q[wr_ptr] <= push_tid;
         ok_q[wr_ptr]  <= push_ok;
      end
   end

endmodule

// File: rtl/pcmd_act_stage.sv
module pcmd_act_stage
   import pcmd_pkg::*;
#(
   parameter int MASK_W = 32,
   parameter int VM_W = 3,
   parameter int TID_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  pwr_act_e          in_op,
   input  logic [MASK_W-1:0] in_mask,
   input  logic [VM_W-1:0]   in_vmode,
   input  logic [TID_W-1:0]  in_tid,
   output logic              out_valid,
   output pwr_act_e          out_op,
   output logic [MASK_W-1:0] out_mask,
   output logic [VM_W-1:0]   out_vmode,
   output logic [TID_W-1:0]  out_tid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_op    <= ACT_RESET;
         out_mask  <= '0;
         out_vmode <= '0;
         out_tid   <= '0;
      end else begin
         out_valid <= fire;
         if (fire) begin
            out_op    <= in_op;
            out_mask  <= in_mask;
            out_vmode <= in_vmode;
            out_tid   <= in_tid;
         end
      end
   end

endmodule

// File: rtl/pcmd_target.sv
module pcmd_target
   import pcmd_pkg::*;
#(
   parameter int DOM_W = 7,
   parameter int MASK_W = 32,
   parameter int VM_W = 3,
   parameter int TID_W = 4,
   parameter int DEPTH = 4,
   parameter logic [DOM_W-1:0] MY_DOM = 7'h2A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_cmd,
   input  logic [DOM_W-1:0]  req_dom,
   input  logic              req_kind,
   input  logic [MASK_W-1:0] req_mask,
   input  logic [VM_W-1:0]   req_vmode,
   input  logic [TID_W-1:0]  req_tid,
   output logic              req_accept,
   output logic              act_valid,
   output logic [1:0]        act_op,
   output logic [MASK_W-1:0] act_mask,
   output logic [VM_W-1:0]   act_vmode,
   output logic [TID_W-1:0]  act_tid,
   output logic              rsp_valid,
   output logic [TID_W-1:0]  rsp_tid,
   output logic              rsp_ok,
   input  logic              rsp_accept
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("pcmd_target: DEPTH must be at least 1");
      end
      if (DOM_W < 1 || MASK_W < 1 || VM_W < 1 || TID_W < 1) begin : g_bad_width
         $error("pcmd_target: field widths must be positive");
      end
   endgenerate

   logic              hit, known, q_full, q_empty, taken;
   pwr_act_e          dec_op, st_op;
   logic [MASK_W-1:0] dec_mask;
   logic [VM_W-1:0]   dec_vmode;

   pcmd_decode #(
      .DOM_W(DOM_W), .MASK_W(MASK_W), .VM_W(VM_W), .MY_DOM(MY_DOM)
   ) u_dec (
      .cmd(req_cmd), .dom(req_dom), .kind(req_kind), .mask(req_mask),
      .vmode(req_vmode), .hit(hit), .known(known), .op(dec_op),
      .eff_mask(dec_mask), .eff_vmode(dec_vmode)
   );

   assign req_accept = !q_full;
   assign taken      = req_valid && req_accept;

   pcmd_resp_fifo #(.DEPTH(DEPTH), .TID_W(TID_W)) u_rsp (
      .clk(clk), .rst_n(rst_n),
      .push(taken && hit), .push_tid(req_tid), .push_ok(known),
      .pop(rsp_accept), .full(q_full), .empty(q_empty),
      .head_tid(rsp_tid), .head_ok(rsp_ok)
   );

   assign rsp_valid = !q_empty;

   pcmd_act_stage #(.MASK_W(MASK_W), .VM_W(VM_W), .TID_W(TID_W)) u_act (
      .clk(clk), .rst_n(rst_n),
      .fire(taken && hit && known), .in_op(dec_op), .in_mask(dec_mask),
      .in_vmode(dec_vmode), .in_tid(req_tid),
      .out_valid(act_valid), .out_op(st_op), .out_mask(act_mask),
      .out_vmode(act_vmode), .out_tid(act_tid)
   );

   assign act_op = st_op;

endmodule

// File: rtl/pcmd_target_chk.sv
module pcmd_target_chk #(
   parameter int DOM_W = 7,
   parameter int MASK_W = 32,
   parameter int VM_W = 3,
   parameter int TID_W = 4,
   parameter int DEPTH = 4,
   parameter logic [DOM_W-1:0] MY_DOM = 7'h2A
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [2:0]        req_cmd,
   input logic [DOM_W-1:0]  req_dom,
   input logic              req_kind,
   input logic [MASK_W-1:0] req_mask,
   input logic [VM_W-1:0]   req_vmode,
   input logic [TID_W-1:0]  req_tid,
   input logic              req_accept,
   input logic              act_valid,
   input logic [1:0]        act_op,
   input logic [MASK_W-1:0] act_mask,
   input logic [VM_W-1:0]   act_vmode,
   input logic [TID_W-1:0]  act_tid,
   input logic              rsp_valid,
   input logic [TID_W-1:0]  rsp_tid,
   input logic              rsp_ok,
   input logic              rsp_accept
);

   logic [7:0] pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else pend <= pend + 8'((req_valid && req_accept && req_dom == MY_DOM) ? 1 : 0)
                        - 8'((rsp_valid && rsp_accept) ? 1 : 0);
   end

   p_act_follows_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> $past(req_valid && req_accept));

   p_act_own_domain_r2: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> $past(req_dom) == MY_DOM);

   p_whole_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && $past(req_kind) == 1'b0) |-> &act_mask);

   p_vmode_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && act_op != 2'd3) |-> act_vmode == '0);

   p_rsp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_accept) |=> (rsp_valid && $stable(rsp_tid) && $stable(rsp_ok)));

   p_no_unknown_dispatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> !$past(req_cmd[2]));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= 8'(DEPTH));

   p_full_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == 8'(DEPTH)) |-> !req_accept);

   p_rsp_matches_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == (pend != '0));

endmodule

bind pcmd_target pcmd_target_chk #(
   .DOM_W(DOM_W), .MASK_W(MASK_W), .VM_W(VM_W), .TID_W(TID_W),
   .DEPTH(DEPTH), .MY_DOM(MY_DOM)
) u_chk (.*);

// File: tb/pcmd_target_bench.sv
`timescale 1ns/1ps
module pcmd_target_bench;

   localparam int DOM_W = 7, MASK_W = 32, VM_W = 3, TID_W = 4, DEPTH = 4;
   localparam logic [DOM_W-1:0] MY_DOM = 7'h2A;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_kind = 1'b0, rsp_accept = 1'b0;
   logic [2:0] req_cmd = '0;
   logic [DOM_W-1:0] req_dom = '0;
   logic [MASK_W-1:0] req_mask = '0;
   logic [VM_W-1:0] req_vmode = '0;
   logic [TID_W-1:0] req_tid = '0;
   logic req_accept, act_valid, rsp_valid, rsp_ok;
   logic [1:0] act_op;
   logic [MASK_W-1:0] act_mask;
   logic [VM_W-1:0] act_vmode;
   logic [TID_W-1:0] act_tid, rsp_tid;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pcmd_target #(.DOM_W(DOM_W), .MASK_W(MASK_W), .VM_W(VM_W), .TID_W(TID_W),
                 .DEPTH(DEPTH), .MY_DOM(MY_DOM)) u_pcmd_target (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
      .req_dom(req_dom), .req_kind(req_kind), .req_mask(req_mask),
      .req_vmode(req_vmode), .req_tid(req_tid), .req_accept(req_accept),
      .act_valid(act_valid), .act_op(act_op), .act_mask(act_mask),
      .act_vmode(act_vmode), .act_tid(act_tid), .rsp_valid(rsp_valid),
      .rsp_tid(rsp_tid), .rsp_ok(rsp_ok), .rsp_accept(rsp_accept)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic one_cmd(input logic [2:0] cmd, input logic kind, input bit mine,
                          input logic [MASK_W-1:0] mask, input logic [VM_W-1:0] vm,
                          input logic [TID_W-1:0] tid);
      bit disp;
      @(negedge clk);
      req_valid = 1'b1; req_cmd = cmd; req_kind = kind; req_mask = mask;
      req_vmode = vm; req_tid = tid; req_dom = mine ? MY_DOM : (MY_DOM ^ 7'h01);
      check("R2 accept", 64'(req_accept), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      disp = mine && (cmd < 3'd4);
      check(mine ? "R7 dispatch gate" : "R2 no dispatch", 64'(act_valid), 64'(disp));
      if (disp) begin
         check("R1 op", 64'(act_op), 64'(cmd[1:0]));
         check("R1 tid", 64'(act_tid), 64'(tid));
         check(kind ? "R4 mask" : "R3 mask", 64'(act_mask),
               kind ? 64'(mask) : 64'(32'hFFFF_FFFF));
         check("R5 vmode", 64'(act_vmode), (cmd == 3'd3) ? 64'(vm) : 64'd0);
      end
      check(mine ? "R8 rsp present" : "R2 no rsp", 64'(rsp_valid), 64'(mine));
      if (mine) begin
         check("R8 rsp tid", 64'(rsp_tid), 64'(tid));
         check("R7 rsp ok", 64'(rsp_ok), 64'(cmd < 3'd4));
         rsp_accept = 1'b1;
         @(negedge clk);
         rsp_accept = 1'b0;
         check("R1 strobe one cycle", 64'(act_valid), 64'd0);
         check("R6 rsp taken", 64'(rsp_valid), 64'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R10 accept", 64'(req_accept), 64'd1);
      check("R10 act", 64'(act_valid), 64'd0);
      check("R10 rsp", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int c = 0; c < 8; c++)
         for (int k = 0; k < 2; k++)
            for (int m = 0; m < 2; m++)
               one_cmd(3'(c), 1'(k), m[0], 32'h1357_0000 ^ (32'(c) << 8) ^ 32'(k * 3 + m),
                       3'(c + k + 1), 4'(c * 2 + k));
      // R9: fill the queue while responses are held back
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         req_valid = 1'b1; req_cmd = 3'(i); req_kind = 1'b0; req_dom = MY_DOM;
         req_tid = 4'(9 + i);
         check("R9 accept while room", 64'(req_accept), 64'd1);
      end
      @(negedge clk);
      req_tid = 4'd13; req_cmd = 3'd5;
      check("R9 stalled when full", 64'(req_accept), 64'd0);
      @(negedge clk);
      check("R9 still stalled", 64'(req_accept), 64'd0);
      check("R6 head tid held", 64'(rsp_tid), 64'd9);
      check("R6 head valid held", 64'(rsp_valid), 64'd1);
      rsp_accept = 1'b1;
      @(negedge clk);
      rsp_accept = 1'b0;
      check("R9 reopen after pop", 64'(req_accept), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         check("R8 order valid", 64'(rsp_valid), 64'd1);
         check("R8 order tid", 64'(rsp_tid), 64'(10 + i));
         check("R7 order ok", 64'(rsp_ok), 64'(i != DEPTH - 1));
         rsp_accept = 1'b1;
         @(negedge clk);
         rsp_accept = 1'b0;
      end
      check("R8 drained", 64'(rsp_valid), 64'd0);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule